// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits in the front end of a multithreaded processor and decides, cycle by cycle, which hardware thread is allowed to fetch. For every thread it sees an active bit, a fetch-state code, and the occupancy counts that the back end reports for that thread's instruction queue and load/store queue. A static policy input picks one of four selection rules. The block returns a thread number and a valid flag.

The selection is a purely combinational function of the inputs and of one piece of state: an ordered list of thread numbers used by the rotating policy. Whenever the rotating policy produces a grant, the granted thread moves to the back of that list at the next clock edge. A deactivate strobe takes a thread out of the list for good, until the next reset. The occupancy policies favour the thread whose back-end queue is least full. The single-thread policy only ever considers the lowest-numbered active thread.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread can be granted only when its active bit is 1 and its 3-bit state code is 0 (running), 1 (line filled) or 2 (idle). Codes 3 to 7 make the thread ineligible.
- R2: With policy code 0 (single), the only candidate is the lowest-numbered thread whose active bit is set. It is granted when eligible. Otherwise the output is invalid, even if other threads are eligible.
- R3: With policy code 1 (rotate), the list is scanned from its head and the first eligible thread in it is granted.
- R4: In rotate mode, a valid grant moves the granted thread to the tail of the list at the next clock edge, and the other entries keep their order. The list does not change in any other mode, nor when no thread is granted.
- R5: With policy code 2, the eligible thread with the smallest instruction-queue count is granted.
- R6: With policy code 3, the eligible thread with the smallest load/store-queue count is granted.
- R7: Under codes 2 and 3, when counts are equal the lower thread number wins.
- R8: When no candidate is eligible, sel_valid is 0 and sel_tid is 0.
- R9: Policy codes 4 to 7 are reserved. Code 4 stands for a branch-count rule that is not built. All of these codes give sel_valid 0.
- R10: After reset the list holds every thread in ascending order, 0 first.
- R11: A deactivate strobe removes that thread from the list and keeps the order of the remaining entries. A strobe naming a thread that is not in the list has no effect.
- R12: When a rotate grant and a deactivate strobe land in the same cycle, the rotation is applied first and the removal second. A thread that is granted and deactivated in that cycle leaves the list instead of going to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 3 | Selection rule code |
| thread_active | input | N | Per-thread active bits |
| thread_state | input | 3*N | Per-thread fetch-state codes; thread i sits at bits [3i+2:3i] |
| iq_occ | input | CNT_W*N | Per-thread instruction-queue counts |
| lsq_occ | input | CNT_W*N | Per-thread load/store-queue counts |
| deact_valid | input | 1 | Remove a thread from the rotation list |
| deact_tid | input | TID_W | Thread to remove |
| sel_valid | output | 1 | A thread is granted this cycle |
| sel_tid | output | TID_W | Granted thread, 0 when not valid |

## Verification
Two things can happen to the rotation list in the same edge: the move-to-tail caused by a rotate grant, and the removal caused by a deactivate strobe. The bench provokes this directly by deactivating the very thread being granted, and also a different thread in that cycle. Randomised cycles keep mixing strobes with rotate grants. The result is judged by reading the list back through later rotate grants while all threads are eligible, and comparing the order of grants with a reference list kept in the bench.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int STATE_W  = 3;
    localparam int POLICY_W = 3;

    // Fetch-state codes; only the first three allow fetching.
    localparam logic [STATE_W-1:0] ST_RUNNING   = 3'd0;
    localparam logic [STATE_W-1:0] ST_FILLED    = 3'd1;
    localparam logic [STATE_W-1:0] ST_IDLE      = 3'd2;
    localparam logic [STATE_W-1:0] ST_BLOCKED   = 3'd3;
    localparam logic [STATE_W-1:0] ST_SQUASHING = 3'd4;
    localparam logic [STATE_W-1:0] ST_MISS_WAIT = 3'd5;
    localparam logic [STATE_W-1:0] ST_TRAP      = 3'd6;
    localparam logic [STATE_W-1:0] ST_QUIESCE   = 3'd7;

    typedef enum logic [POLICY_W-1:0] {
        POL_SINGLE     = 3'd0,
        POL_ROTATE     = 3'd1,
        POL_IQ_LOW     = 3'd2,
        POL_LSQ_LOW    = 3'd3,
        POL_BRANCH_RSV = 3'd4
    } policy_e;

    function automatic logic state_can_fetch(input logic [STATE_W-1:0] st);
        return (st == ST_RUNNING) || (st == ST_FILLED) || (st == ST_IDLE);
    endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig #(
    parameter int N = 4
) (
    input  logic [N-1:0]                   act,
    input  logic [N*fsel_pkg::STATE_W-1:0] st_flat,
    output logic [N-1:0]                   elig
);
    localparam int SW = fsel_pkg::STATE_W;

    for (genvar gi = 0; gi < N; gi++) begin : g_thr
        assign elig[gi] = act[gi] && fsel_pkg::state_can_fetch(st_flat[gi*SW +: SW]);
    end
endmodule

// File: rtl/fsel_occ_pick.sv
module fsel_occ_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]       elig,
    input  logic [N*CNT_W-1:0] cnt_flat,
    output logic               pick_valid,
    output logic [TID_W-1:0]   pick_tid
);
    logic [CNT_W-1:0] cnt [N];
    logic [CNT_W-1:0] best_cnt;

    for (genvar gi = 0; gi < N; gi++) begin : g_unpack
        assign cnt[gi] = cnt_flat[gi*CNT_W +: CNT_W];
    end

    // Strict less-than keeps the lowest thread number on equal counts.
    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        best_cnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!pick_valid || cnt[i] < best_cnt)) begin
                pick_valid = 1'b1;
                pick_tid   = TID_W'(i);
                best_cnt   = cnt[i];
            end
        end
    end
endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list #(
    parameter int N     = 4,
    parameter int TID_W = 2,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     elig,
    input  logic             advance,
    input  logic             deact_valid,
    input  logic [TID_W-1:0] deact_tid,
    output logic             pick_valid,
    output logic [TID_W-1:0] pick_tid
);
    logic [TID_W-1:0] list_q   [N];
    logic [TID_W-1:0] list_mid [N];
    logic [TID_W-1:0] list_nxt [N];
    logic [LEN_W-1:0] len_q, len_nxt;
    logic [TID_W-1:0] tail_tid;
    logic             hit;
    int               pick_pos, hit_pos;

    // Scan from the head for the first eligible entry.
    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        pick_pos   = 0;
        for (int i = 0; i < N; i++) begin
            if (!pick_valid && i < int'(len_q) && elig[list_q[i]]) begin
                pick_valid = 1'b1;
                pick_tid   = list_q[i];
                pick_pos   = i;
            end
        end
    end

    // Step one: move the granted entry to the tail.
    always_comb begin
        list_mid = list_q;
        if (advance && pick_valid) begin
            for (int i = 0; i < N; i++) begin
                if (i >= pick_pos && i < int'(len_q) - 1)
                    list_mid[i] = list_q[(i + 1 < N) ? i + 1 : i];
                else if (i == int'(len_q) - 1)
                    list_mid[i] = pick_tid;
            end
        end
    end

    // Step two: drop the deactivated thread and close the gap.
    always_comb begin
        hit     = 1'b0;
        hit_pos = 0;
        for (int i = 0; i < N; i++) begin
            if (!hit && deact_valid && i < int'(len_q) && list_mid[i] == deact_tid) begin
                hit     = 1'b1;
                hit_pos = i;
            end
        end
        list_nxt = list_mid;
        len_nxt  = len_q;
        if (hit) begin
            for (int i = 0; i < N; i++) begin
                if (i >= hit_pos && i < int'(len_q) - 1)
                    list_nxt[i] = list_mid[(i + 1 < N) ? i + 1 : i];
            end
            len_nxt = len_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) list_q[i] <= TID_W'(i);
            len_q <= LEN_W'(N);
        end else begin
            list_q <= list_nxt;
            len_q  <= len_nxt;
        end
    end

    always_comb begin
        tail_tid = '0;
        for (int i = 0; i < N; i++)
            if (i == int'(len_q) - 1) tail_tid = list_q[i];
    end

    assert_len_never_grows_R11: assert property (@(posedge clk) disable iff (rst)
        len_q <= $past(len_q));

    assert_grant_to_tail_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && pick_valid && !deact_valid) |=> (tail_tid == $past(pick_tid)));

    assert_removal_shrinks_R11: assert property (@(posedge clk) disable iff (rst)
        (deact_valid && hit) |=> (len_q + 1'b1 == $past(len_q)));

    assert_idle_list_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !deact_valid) |=> $stable(len_q));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
    parameter  int N     = 4,
    parameter  int CNT_W = 6,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1,
    localparam int LEN_W = $clog2(N + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [fsel_pkg::POLICY_W-1:0]  policy_sel,
    input  logic [N-1:0]                   thread_active,
    input  logic [N*fsel_pkg::STATE_W-1:0] thread_state,
    input  logic [N*CNT_W-1:0]             iq_occ,
    input  logic [N*CNT_W-1:0]             lsq_occ,
    input  logic                           deact_valid,
    input  logic [TID_W-1:0]               deact_tid,
    output logic                           sel_valid,
    output logic [TID_W-1:0]               sel_tid
);
    import fsel_pkg::*;

    logic [N-1:0]     elig;
    logic             rr_valid, iq_valid, lsq_valid, solo_valid, solo_found;
    logic [TID_W-1:0] rr_tid, iq_tid, lsq_tid, solo_tid;
    logic             rr_advance;

    fsel_elig #(.N(N)) u_elig (
        .act     (thread_active),
        .st_flat (thread_state),
        .elig    (elig)
    );

    fsel_occ_pick #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) u_iq_pick (
        .elig       (elig),
        .cnt_flat   (iq_occ),
        .pick_valid (iq_valid),
        .pick_tid   (iq_tid)
    );

    fsel_occ_pick #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) u_lsq_pick (
        .elig       (elig),
        .cnt_flat   (lsq_occ),
        .pick_valid (lsq_valid),
        .pick_tid   (lsq_tid)
    );

    assign rr_advance = (policy_sel == POL_ROTATE);

    fsel_rr_list #(.N(N), .TID_W(TID_W), .LEN_W(LEN_W)) u_rr_list (
        .clk         (clk),
        .rst         (rst),
        .elig        (elig),
        .advance     (rr_advance),
        .deact_valid (deact_valid),
        .deact_tid   (deact_tid),
        .pick_valid  (rr_valid),
        .pick_tid    (rr_tid)
    );

    // Single mode: the lowest active thread is the only candidate.
    always_comb begin
        solo_found = 1'b0;
        solo_tid   = '0;
        for (int i = 0; i < N; i++) begin
            if (!solo_found && thread_active[i]) begin
                solo_found = 1'b1;
                solo_tid   = TID_W'(i);
            end
        end
        solo_valid = solo_found && elig[solo_tid];
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_tid   = '0;
        case (policy_sel)
            POL_SINGLE:  begin sel_valid = solo_valid; sel_tid = solo_tid; end
            POL_ROTATE:  begin sel_valid = rr_valid;   sel_tid = rr_tid;   end
            POL_IQ_LOW:  begin sel_valid = iq_valid;   sel_tid = iq_tid;   end
            POL_LSQ_LOW: begin sel_valid = lsq_valid;  sel_tid = lsq_tid;  end
            default:     begin sel_valid = 1'b0;       sel_tid = '0;       end
        endcase
        if (!sel_valid) sel_tid = '0;
    end

    assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (thread_active[sel_tid] &&
                       thread_state[sel_tid*STATE_W +: STATE_W] <= ST_IDLE));

    assert_reserved_no_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (policy_sel >= POL_BRANCH_RSV) |-> !sel_valid);

    assert_single_lowest_R2: assert property (@(posedge clk) disable iff (rst)
        (policy_sel == POL_SINGLE && sel_valid) |->
            ((thread_active & ~({N{1'b1}} << sel_tid)) == '0));

    assert_invalid_zero_tid_R8: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> (sel_tid == '0));
endmodule

// File: tb/fetch_thread_sel_tb.sv
`timescale 1ns/100ps
module fetch_thread_sel_tb;
    localparam int N     = 4;
    localparam int CNT_W = 6;
    localparam int TID_W = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [2:0]         policy_sel = '0;
    logic [N-1:0]       thread_active = '0;
    logic [N*3-1:0]     thread_state = '0;
    logic [N*CNT_W-1:0] iq_occ = '0;
    logic [N*CNT_W-1:0] lsq_occ = '0;
    logic               deact_valid = 1'b0;
    logic [TID_W-1:0]   deact_tid = '0;
    logic               sel_valid;
    logic [TID_W-1:0]   sel_tid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int m_list [N];
    int m_len;

    always #2.5 clk = ~clk;

    fetch_thread_sel #(.N(N), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .policy_sel(policy_sel),
        .thread_active(thread_active), .thread_state(thread_state),
        .iq_occ(iq_occ), .lsq_occ(lsq_occ),
        .deact_valid(deact_valid), .deact_tid(deact_tid),
        .sel_valid(sel_valid), .sel_tid(sel_tid)
    );

    function automatic bit m_elig(int i);
        return thread_active[i] && (thread_state[i*3 +: 3] <= 3'd2);
    endfunction

    function automatic void model_pick(output bit v, output int t);
        int best;
        v = 0; t = 0; best = 0;
        case (policy_sel)
            3'd0: begin
                for (int i = N - 1; i >= 0; i--) if (thread_active[i]) t = i;
                v = (thread_active != '0) && m_elig(t);
            end
            3'd1: begin
                for (int i = 0; i < m_len; i++)
                    if (!v && m_elig(m_list[i])) begin v = 1; t = m_list[i]; end
            end
            3'd2, 3'd3: begin
                for (int i = 0; i < N; i++) begin
                    int c;
                    c = (policy_sel == 3'd2) ? int'(iq_occ[i*CNT_W +: CNT_W])
                                             : int'(lsq_occ[i*CNT_W +: CNT_W]);
                    if (m_elig(i) && (!v || c < best)) begin v = 1; t = i; best = c; end
                end
            end
            default: v = 0;
        endcase
        if (!v) t = 0;
    endfunction

    task automatic check(input string req, input bit ev, input int et);
        checks++;
        if (sel_valid !== ev || int'(sel_tid) != et) begin
            errors++;
            $display("FAIL %s: got valid=%0d tid=%0d, expected valid=%0d tid=%0d",
                     req, sel_valid, sel_tid, ev, et);
        end
    endtask

    task automatic check_model(input string req);
        bit v; int t;
        model_pick(v, t);
        check(req, v, t);
    endtask

    // Apply the list update rules to the model, then clock the design.
    task automatic advance();
        bit v; int t; int pos;
        model_pick(v, t);
        if (policy_sel == 3'd1 && v) begin
            pos = 0;
            for (int i = 0; i < m_len; i++) if (m_list[i] == t) pos = i;
            for (int i = pos; i < m_len - 1; i++) m_list[i] = m_list[i + 1];
            m_list[m_len - 1] = t;
        end
        if (deact_valid) begin
            pos = -1;
            for (int i = 0; i < m_len; i++) if (pos < 0 && m_list[i] == int'(deact_tid)) pos = i;
            if (pos >= 0) begin
                for (int i = pos; i < m_len - 1; i++) m_list[i] = m_list[i + 1];
                m_len--;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        deact_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) m_list[i] = i;
        m_len = N;
    endtask

    task automatic all_eligible();
        thread_active = '1;
        thread_state  = '0;
    endtask

    task automatic set_state(input int i, input logic [2:0] s);
        thread_state[i*3 +: 3] = s;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R10, R3, R4: fresh list grants 0,1,2,3 then wraps.
        all_eligible();
        policy_sel = 3'd1;
        for (int k = 0; k < N + 1; k++) begin
            #1 check("R10", 1, k % N);
            advance();
        end

        // R3 and R1: a blocked head is skipped.
        do_reset();
        all_eligible();
        policy_sel = 3'd1;
        set_state(0, 3'd3);
        #1 check("R3", 1, 1);
        advance();
        // R4: held list under other modes; grants continue 2 then 3.
        policy_sel = 3'd2;
        iq_occ = '0;
        #1 check("R5", 1, 1);
        advance();
        policy_sel = 3'd1;
        #1 check("R4", 1, 2);
        advance();

        // R11: removal outside rotate mode, then an unknown removal.
        do_reset();
        all_eligible();
        policy_sel = 3'd0;
        deact_valid = 1'b1; deact_tid = 2'd2;
        #1 check("R2", 1, 0);
        advance();
        #1 check("R11", 1, 0);
        advance();
        deact_valid = 1'b0;
        policy_sel = 3'd1;
        for (int k = 0; k < 4; k++) begin
            int exp_seq [4] = '{0, 1, 3, 0};
            #1 check("R11", 1, exp_seq[k]);
            advance();
        end

        // R12: deactivate the thread being granted in the same cycle.
        do_reset();
        all_eligible();
        policy_sel = 3'd1;
        deact_valid = 1'b1; deact_tid = 2'd0;
        #1 check("R12", 1, 0);
        advance();
        deact_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1 check("R12", 1, (k % 3) + 1);
            advance();
        end
        // R12: grant 2 while removing 3 in the same cycle; list becomes 1,2.
        deact_valid = 1'b1; deact_tid = 2'd3;
        #1 check("R12", 1, 2);
        advance();
        deact_valid = 1'b0;
        #1 check("R12", 1, 1);
        advance();
        #1 check("R12", 1, 2);
        advance();

        // R7, R5: equal lowest counts go to the lower thread.
        all_eligible();
        policy_sel = 3'd2;
        iq_occ = {6'd5, 6'd1, 6'd1, 6'd3};
        #1 check("R7", 1, 1);
        advance();
        // R6: load/store counts, with the minimum thread ineligible.
        policy_sel = 3'd3;
        lsq_occ = {6'd1, 6'd0, 6'd2, 6'd4};
        set_state(2, 3'd5);
        #1 check("R6", 1, 3);
        advance();

        // R2: lowest active thread blocked gives no grant.
        policy_sel = 3'd0;
        thread_active = 4'b1100;
        thread_state = '0;
        set_state(2, 3'd4);
        #1 check("R2", 0, 0);
        advance();
        set_state(2, 3'd1);
        #1 check("R2", 1, 2);
        advance();

        // R9: reserved codes never grant.
        all_eligible();
        for (int p = 4; p < 8; p++) begin
            policy_sel = 3'(p);
            #1 check("R9", 0, 0);
            advance();
        end
        // R8, R1: nothing eligible in any mode.
        thread_active = '1;
        for (int i = 0; i < N; i++) set_state(i, 3'(3 + i));
        for (int p = 0; p < 4; p++) begin
            policy_sel = 3'(p);
            #1 check("R8", 0, 0);
            advance();
        end

        // Random mix checked against the reference model.
        do_reset();
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 250 == 249) do_reset();
            policy_sel = ($urandom_range(0, 9) < 5) ? 3'd1 : 3'($urandom_range(0, 7));
            thread_active = ($urandom_range(0, 3) == 0) ? 4'($urandom) : '1;
            for (int i = 0; i < N; i++)
                set_state(i, ($urandom_range(0, 3) == 0) ? 3'($urandom_range(3, 7))
                                                       : 3'($urandom_range(0, 2)));
            for (int i = 0; i < N; i++) begin
                iq_occ[i*CNT_W +: CNT_W]  = CNT_W'($urandom_range(0, 5));
                lsq_occ[i*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, 5));
            end
            deact_valid = ($urandom_range(0, 19) == 0);
            deact_tid   = TID_W'($urandom);
            #1;
            case (policy_sel)
                3'd0: check_model("R2");
                3'd1: check_model(deact_valid ? "R12" : "R4");
                3'd2: check_model("R5");
                3'd3: check_model("R6");
                default: check_model("R9");
            endcase
            advance();
        end

        finish_run();
    end
endmodule